// File: doc/BRIEF.md
# Chained Acquisition Memory Address Sequencer

The block writes digitized samples into a row of cascaded memory cards in strict order. A converter raises an asynchronous valid-data strobe for each sample. The block first brings the strobe into the local clock domain and detects its edges. On the leading edge it stores the data bus at the current address. On the trailing edge it moves the address on by one. The address is split into a card field, which is the top two bits, and a word field below it. When the top word of one card has been written, the next trailing edge moves the address to word zero of the next card. That card then becomes the active one.

Between acquisitions a host uses three register strobes. It can load the address, peek at the word at the current address, or read that word and advance the address in one command. The current address can be read at any time. The host must not move the address while acquisition is running. Such a write is ignored and raises a sticky error flag. A load that names a card beyond the installed count is treated the same way. When the final word of the last installed card has been written, the block enters a full state. The address then holds, and further samples are dropped until the host loads a new address.

The controller has three states. ST_WAIT waits for a leading edge. ST_HELD means the sample is written and the block waits for the trailing edge. ST_FULL means the last card is exhausted. The transitions are:
- ST_WAIT to ST_HELD on a leading edge while acquisition runs.
- ST_HELD to ST_WAIT on a trailing edge below the final address.
- ST_HELD to ST_FULL on a trailing edge at the final address.
- ST_WAIT to ST_FULL on a read-and-advance at the final address.
- ST_FULL to ST_WAIT on an accepted address load.

Each card holds 2**CARD_AW words. A 1 Mbyte card of 16-bit words uses CARD_AW = 19.

Top module: `acq_addr_seq`

## Requirements
- R1: After reset, `cur_addr` is 0, `full`, `addr_err` and `rd_valid` are 0, and `card_en` is 4'b0001.
- R2: On the leading edge of `vdv_async` while `acq_run` is 1, the value of `smp_data` at that edge is written to `cur_addr`. Changing `smp_data` later while the strobe stays high has no effect. `cur_addr` does not change while the strobe is high.
- R3: The trailing edge of `vdv_async` that follows a written sample increments `cur_addr` by one.
- R4: `card_en` is one-hot, and bit k is set when `cur_addr[CARD_AW+1:CARD_AW]` equals k. Moving past the top word of card k selects card k+1 at word 0.
- R5: A `host_addr_wr` pulse while `acq_run` is 0 and no sample is pending loads `host_addr` into `cur_addr`.
- R6: A `host_addr_wr` pulse while acquisition runs, or one naming a card at or beyond NUM_CARDS, leaves `cur_addr` unchanged and sets the sticky `addr_err`. An accepted load clears `addr_err`.
- R7: A `host_rd` pulse gives the word at `cur_addr` on `rd_data` with `rd_valid` one cycle later, and leaves `cur_addr` unchanged.
- R8: A `host_rd_adv` pulse gives the word at `cur_addr` one cycle later and increments `cur_addr`.
- R9: After the trailing edge at the last word of the last installed card, `full` is 1 and `cur_addr` holds. Further samples are not written. A read-and-advance there also holds the address and sets `full`.
- R10: An accepted address load clears `full`.
- R11: Strobe edges while `acq_run` is 0 neither write nor change `cur_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low reset |
| vdv_async | input | 1 | Asynchronous valid-data strobe from the converter |
| smp_data | input | WORD_W | Sample data bus |
| acq_run | input | 1 | Acquisition active |
| host_addr_wr | input | 1 | Host address-load strobe |
| host_addr | input | CARD_AW+2 | Address to load |
| host_rd | input | 1 | Host peek strobe |
| host_rd_adv | input | 1 | Host read-and-advance strobe |
| cur_addr | output | CARD_AW+2 | Current address, card field on top |
| card_en | output | 4 | One-hot active card |
| rd_data | output | WORD_W | Host read data |
| rd_valid | output | 1 | `rd_data` valid, one cycle after a read |
| full | output | 1 | Last installed card exhausted |
| addr_err | output | 1 | Sticky flag for a rejected address load |

## Verification
A wrong controller state shows up at the ports within one sample. A state stuck in ST_HELD stops `cur_addr` from advancing after the trailing edge, which is visible about three clocks after that edge. A state that misses ST_FULL lets a dropped sample move the address or overwrite the last word, and a peek returns that wrong word one cycle after it is issued. A wrong card decode appears at once on `card_en`. Wrong write data stays hidden until the host reads it back, so every stored word is compared during readback.

// File: rtl/acq_seq_pkg.sv
package acq_seq_pkg;
    localparam int MAX_CARDS = 4;
    localparam int SEL_W     = 2;

    typedef enum logic [1:0] {
        ST_WAIT = 2'd0,
        ST_HELD = 2'd1,
        ST_FULL = 2'd2
    } seq_state_t;
endpackage

// File: rtl/acq_strobe_sync.sv
module acq_strobe_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_async,
    output logic rise,
    output logic fall
);
    logic s1, s2, s3;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
            s3 <= 1'b0;
        end else begin
            s1 <= strobe_async;
            s2 <= s1;
            s3 <= s2;
        end
    end

    assign rise = s2 & ~s3;
    assign fall = ~s2 & s3;
endmodule

// File: rtl/acq_card_ram.sv
module acq_card_ram #(
    parameter int WORD_W = 16,
    parameter int AW     = 3
) (
    input  logic              clk,
    input  logic              we,
    input  logic              re,
    input  logic [AW-1:0]     addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata
);
    localparam int DEPTH = 2 ** AW;

    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
        if (re) rdata <= mem[addr];
    end
endmodule

// File: rtl/acq_addr_seq.sv
module acq_addr_seq
    import acq_seq_pkg::*;
#(
    parameter int WORD_W    = 16,
    parameter int CARD_AW   = 3,
    parameter int NUM_CARDS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 vdv_async,
    input  logic [WORD_W-1:0]    smp_data,
    input  logic                 acq_run,
    input  logic                 host_addr_wr,
    input  logic [CARD_AW+1:0]   host_addr,
    input  logic                 host_rd,
    input  logic                 host_rd_adv,
    output logic [CARD_AW+1:0]   cur_addr,
    output logic [MAX_CARDS-1:0] card_en,
    output logic [WORD_W-1:0]    rd_data,
    output logic                 rd_valid,
    output logic                 full,
    output logic                 addr_err
);
    localparam int ADDR_W = CARD_AW + SEL_W;
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_CARDS * (2 ** CARD_AW) - 1);

    seq_state_t state, nxt;
    logic rise, fall;
    logic ram_we, addr_inc, host_ok, addr_ok, rd_go, at_last, addr_bad;
    logic [SEL_W-1:0] sel, rd_card_q;
    logic [WORD_W-1:0] card_q [MAX_CARDS];

    acq_strobe_sync u_sync (
        .clk          (clk),
        .rst_n        (rst_n),
        .strobe_async (vdv_async),
        .rise         (rise),
        .fall         (fall)
    );

    assign sel      = cur_addr[ADDR_W-1:CARD_AW];
    assign at_last  = (cur_addr == LAST_ADDR);
    assign host_ok  = !acq_run && (state != ST_HELD);
    assign addr_bad = (host_addr > LAST_ADDR);
    assign addr_ok  = host_ok && host_addr_wr && !addr_bad;
    assign rd_go    = host_ok && !host_addr_wr && (host_rd || host_rd_adv);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_WAIT;
        else        state <= nxt;
    end

    // Next state and control outputs
    always_comb begin
        nxt      = state;
        ram_we   = 1'b0;
        addr_inc = 1'b0;
        full     = 1'b0;
        unique case (state)
            ST_WAIT: begin
                if (acq_run && rise) begin
                    ram_we = 1'b1;
                    nxt    = ST_HELD;
                end else if (rd_go && host_rd_adv) begin
                    if (at_last) nxt = ST_FULL;
                    else         addr_inc = 1'b1;
                end
            end
            ST_HELD: begin
                if (fall) begin
                    if (at_last) nxt = ST_FULL;
                    else begin
                        addr_inc = 1'b1;
                        nxt      = ST_WAIT;
                    end
                end
            end
            ST_FULL: begin
                full = 1'b1;
                if (addr_ok) nxt = ST_WAIT;
            end
            default: nxt = ST_WAIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_addr  <= '0;
            addr_err  <= 1'b0;
            rd_valid  <= 1'b0;
            rd_card_q <= '0;
        end else begin
            if (addr_ok)       cur_addr <= host_addr;
            else if (addr_inc) cur_addr <= cur_addr + 1'b1;
            if (host_addr_wr && !addr_ok) addr_err <= 1'b1;
            else if (addr_ok)             addr_err <= 1'b0;
            rd_valid  <= rd_go;
            rd_card_q <= sel;
        end
    end

    always_comb begin
        card_en      = '0;
        card_en[sel] = 1'b1;
    end

    for (genvar i = 0; i < MAX_CARDS; i++) begin : g_card
        if (i < NUM_CARDS) begin : g_fit
            acq_card_ram #(.WORD_W(WORD_W), .AW(CARD_AW)) u_ram (
                .clk   (clk),
                .we    (ram_we && card_en[i]),
                .re    (rd_go && card_en[i]),
                .addr  (cur_addr[CARD_AW-1:0]),
                .wdata (smp_data),
                .rdata (card_q[i])
            );
        end else begin : g_empty
            assign card_q[i] = '0;
        end
    end

    assign rd_data = card_q[rd_card_q];

    // R2: address stays put while the strobe is high
    p_hold_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HELD && !fall) |=> $stable(cur_addr));
    // R3: trailing edge below the final address steps by one
    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HELD && fall && !at_last) |=> (cur_addr == ADDR_W'($past(cur_addr) + 1'b1)));
    // R4: exactly one card active
    p_card_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(card_en) == 1);
    // R6: load during acquisition raises the error flag
    p_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (acq_run && host_addr_wr) |=> addr_err);
    // R7: a host read is answered next cycle
    p_rd_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!acq_run && state == ST_WAIT && host_rd && !host_addr_wr) |=> rd_valid);
    // R9: full holds address and blocks writes
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !addr_ok) |=> (full && $stable(cur_addr)));
    p_full_no_we_r9: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !ram_we);
endmodule

// File: tb/acq_addr_seq_bench.sv
module acq_addr_seq_bench;
    localparam int WORD_W = 16;
    localparam int CARD_AW = 3;
    localparam int AW = CARD_AW + 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vdv_async = 1'b0;
    logic [WORD_W-1:0] smp_data = '0;
    logic acq_run = 1'b0;
    logic host_addr_wr = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic host_rd = 1'b0;
    logic host_rd_adv = 1'b0;
    logic [AW-1:0] cur_addr;
    logic [3:0] card_en;
    logic [WORD_W-1:0] rd_data;
    logic rd_valid, full, addr_err;

    int checks = 0;
    int fails = 0;
    logic [WORD_W-1:0] got;

    always #4 clk = ~clk;

    acq_addr_seq #(.WORD_W(WORD_W), .CARD_AW(CARD_AW), .NUM_CARDS(4)) u_acq_addr_seq (
        .clk(clk), .rst_n(rst_n), .vdv_async(vdv_async), .smp_data(smp_data),
        .acq_run(acq_run), .host_addr_wr(host_addr_wr), .host_addr(host_addr),
        .host_rd(host_rd), .host_rd_adv(host_rd_adv), .cur_addr(cur_addr),
        .card_en(card_en), .rd_data(rd_data), .rd_valid(rd_valid),
        .full(full), .addr_err(addr_err)
    );

    // Samples; expected address after the i-th sample is i+1; crosses card 0 -> 1
    localparam logic [15:0] VEC [10] = '{16'h1234, 16'hBEEF, 16'h0001, 16'h8000, 16'hFFFF,
                                         16'h5555, 16'hAAAA, 16'h0F0F, 16'hC3C3, 16'h7E7E};

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic pulse(input logic [WORD_W-1:0] d);
        @(negedge clk);
        smp_data = d;
        vdv_async = 1'b1;
        repeat (5) @(negedge clk);
        smp_data = ~d;
        vdv_async = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    task automatic set_addr(input logic [AW-1:0] a);
        @(negedge clk);
        host_addr = a;
        host_addr_wr = 1'b1;
        @(negedge clk);
        host_addr_wr = 1'b0;
    endtask

    task automatic host_read(input logic adv, output logic [WORD_W-1:0] d);
        @(negedge clk);
        host_rd = !adv;
        host_rd_adv = adv;
        @(negedge clk);
        host_rd = 1'b0;
        host_rd_adv = 1'b0;
        check("R7 rd_valid", rd_valid, 1);
        d = rd_data;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 cur_addr", cur_addr, 0);
        check("R1 full", full, 0);
        check("R1 addr_err", addr_err, 0);
        check("R1 card_en", card_en, 4'b0001);
        check("R1 rd_valid", rd_valid, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Table walk: store the samples, then read them back with advance
        acq_run = 1'b1;
        for (int i = 0; i < 10; i++) begin
            pulse(VEC[i]);
            check("R3 address step", cur_addr, i + 1);
        end
        check("R4 hand-over to card 1", card_en, 4'b0010);

        set_addr(5'd3);
        repeat (2) @(negedge clk);
        check("R6 locked address", cur_addr, 10);
        check("R6 addr_err set", addr_err, 1);

        acq_run = 1'b0;
        set_addr(5'd0);
        check("R5 address load", cur_addr, 0);
        check("R6 addr_err cleared", addr_err, 0);
        host_read(1'b0, got);
        check("R7 peek data", got, VEC[0]);
        check("R7 peek keeps address", cur_addr, 0);
        for (int i = 0; i < 10; i++) begin
            host_read(1'b1, got);
            check("R2 stored word / R8 data", got, VEC[i]);
            check("R8 read advance", cur_addr, i + 1);
        end

        // R11: strobe while idle does nothing
        set_addr(5'd0);
        pulse(16'hDEAD);
        check("R11 idle strobe keeps address", cur_addr, 0);
        host_read(1'b0, got);
        check("R11 idle strobe no write", got, VEC[0]);

        // R2: address stays while strobe high
        set_addr(5'd12);
        acq_run = 1'b1;
        @(negedge clk);
        smp_data = 16'h4242;
        vdv_async = 1'b1;
        repeat (5) @(negedge clk);
        check("R2 address held while high", cur_addr, 12);
        smp_data = 16'h9999;
        repeat (3) @(negedge clk);
        vdv_async = 1'b0;
        repeat (5) @(negedge clk);
        check("R3 step after trailing edge", cur_addr, 13);
        acq_run = 1'b0;
        set_addr(5'd12);
        host_read(1'b0, got);
        check("R2 leading-edge data", got, 16'h4242);

        // R9: fill the last card
        set_addr(5'd30);
        check("R4 last card", card_en, 4'b1000);
        acq_run = 1'b1;
        pulse(16'hA5A5);
        check("R3 before final", cur_addr, 31);
        check("R9 not yet full", full, 0);
        pulse(16'h5A5A);
        check("R9 full set", full, 1);
        check("R9 address holds", cur_addr, 31);
        pulse(16'hFFFF);
        check("R9 drop keeps address", cur_addr, 31);
        acq_run = 1'b0;
        host_read(1'b1, got);
        check("R9 last word not overwritten", got, 16'h5A5A);
        check("R9 read-advance holds", cur_addr, 31);
        check("R9 still full", full, 1);
        set_addr(5'd0);
        check("R10 full cleared", full, 0);

        // R9: read-advance at final address from a non-full state
        set_addr(5'd31);
        host_read(1'b1, got);
        check("R9 read-advance at end", got, 16'h5A5A);
        check("R9 read-advance sets full", full, 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule